// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Check

This block tracks in-flight loads of an out-of-order core in a circular queue. Loads enter at the tail in program order, each carrying a sequence number. When a load executes, its effective address is written into its slot and the slot is marked executed. An entry that has not executed cannot be matched by any store check.

When a store executes, the block scans the loads from the position that store noted at its own allocation (the load tail at that moment) up to the current tail. It looks for an executed load whose address falls in the same 256-byte region as the store, meaning address bits above bit 7 are equal. The first such load in age order is latched as the violator, and a running violation count goes up. The violator register is sticky. While it holds a pending result, no further scan takes place. A read of the register returns its contents and empties it.

Commit retires loads from the head by sequence number, and squash removes them from the tail. The block also reports how many entries can still be dispatched, taking the store queue's occupancy into account.

Top module: `lq_order_unit`

## Requirements
- R1: The queue holds DEPTH loads (default 8) in DEPTH+1 slots. `lq_full_o` is high when DEPTH loads are held, and an allocation request while full changes nothing.
- R2: An accepted allocation writes the slot at `tail_idx_o` and advances the tail by one, wrapping from slot DEPTH (8) to slot 0. `lq_count_o` counts held loads.
- R3: An execute update for an occupied slot stores the address and marks the slot executed. A load that has not executed never matches a store check.
- R4: A store check scans from `st_chk_start_i` up to, but not including, the tail. A load matches when its address shifted right by 8 equals the store address shifted right by 8. The first match in scan order is latched, and its slot and sequence number appear on `viol_idx_o` and `viol_seq_o` with `viol_valid_o` high one cycle after the check. An empty range or a region mismatch records nothing.
- R5: Each latched violator increments `viol_count_o` by one. A store check made while `viol_valid_o` is high changes neither the violator nor the count.
- R6: While `viol_valid_o` is high, `viol_rd_i` returns the violator on the outputs in that cycle and clears `viol_valid_o` on the next cycle. A store check in the same cycle as such a read is not performed.
- R7: Commit retires consecutive loads from the head while their sequence number is at most `commit_seq_i` (unsigned 32-bit), and stops at the first larger one.
- R8: Squash removes consecutive loads backward from the tail while their sequence number is greater than `squash_seq_i`, and moves the tail back by the number removed.
- R9: `free_count_o` = min(DEPTH+1 − `lq_count_o`, SQ_DEPTH+1 − `sq_used_i`) − 1.
- R10: An allocation in a squash cycle is ignored. An allocation in a commit cycle takes effect together with the retirement. Commit and squash are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Allocate one load at the tail |
| alloc_seq_i | input | 32 | Sequence number of the allocated load |
| tail_idx_o | output | 4 | Current tail slot (slot of the next allocation, noted by stores) |
| lq_full_o | output | 1 | Queue holds DEPTH loads |
| lq_count_o | output | 4 | Number of held loads |
| exec_valid_i | input | 1 | Execute update |
| exec_idx_i | input | 4 | Slot being updated |
| exec_addr_i | input | 32 | Effective address of the executed load |
| st_chk_valid_i | input | 1 | Store check request |
| st_chk_start_i | input | 4 | Load slot recorded by the store at its allocation |
| st_chk_addr_i | input | 32 | Store effective address |
| commit_valid_i | input | 1 | Commit request |
| commit_seq_i | input | 32 | Youngest committed sequence number |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | 32 | Loads newer than this number are removed |
| viol_rd_i | input | 1 | Read and clear the violator |
| viol_valid_o | output | 1 | A violator is pending |
| viol_idx_o | output | 4 | Slot of the violating load |
| viol_seq_o | output | 32 | Sequence number of the violating load |
| viol_count_o | output | 16 | Number of violations recorded |
| sq_used_i | input | 4 | Store-queue occupancy |
| free_count_o | output | 4 | Dispatchable entries |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a violator read together with a new store check. The bench first latches a violator. It then raises `viol_rd_i` and a store check whose region would match in the same cycle. It judges the result by seeing the old violator on the outputs before the edge, `viol_valid_o` low after the edge, and an unchanged count.

The second pair is allocation with commit or squash. After a combined commit and allocation, the bench checks that the count reflects both operations. After a combined squash and allocation, it checks that only the squash took effect, by reading the count and the tail slot.

// File: rtl/lq_order_pkg.sv
package lq_order_pkg;

    // Circular index helpers for a ring of n slots.
    function automatic int unsigned ring_next(input int unsigned i, input int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    function automatic int unsigned ring_prev(input int unsigned i, input int unsigned n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

endpackage

// File: rtl/lq_order_scan.sv
// First-hit finder over a circular range [start, stop).
module lq_order_scan #(
    parameter int SLOTS = 9,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [IDX_W-1:0] stop_i,
    input  logic [SLOTS-1:0] hit_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    import lq_order_pkg::*;

    always_comb begin
        logic [IDX_W-1:0] p;
        logic             live;
        p       = start_i;
        live    = 1'b1;
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (p == stop_i) live = 1'b0;
            if (live && !found_o && (32'(p) < SLOTS) && hit_i[p]) begin
                found_o = 1'b1;
                idx_o   = p;
            end
            p = IDX_W'(ring_next(32'(p), SLOTS));
        end
    end
endmodule

// File: rtl/lq_order_unit.sv
module lq_order_unit #(
    parameter int DEPTH        = 8,
    parameter int SQ_DEPTH     = 8,
    parameter int SEQ_W        = 32,
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 8,
    parameter int VCNT_W       = 16,
    localparam int SLOTS    = DEPTH + 1,
    localparam int SQ_SLOTS = SQ_DEPTH + 1,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int SQC_W    = $clog2(SQ_DEPTH + 1),
    localparam int MAXQ     = (DEPTH > SQ_DEPTH) ? DEPTH : SQ_DEPTH,
    localparam int FREE_W   = $clog2(MAXQ + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [SEQ_W-1:0]  alloc_seq_i,
    output logic [IDX_W-1:0]  tail_idx_o,
    output logic              lq_full_o,
    output logic [CNT_W-1:0]  lq_count_o,
    input  logic              exec_valid_i,
    input  logic [IDX_W-1:0]  exec_idx_i,
    input  logic [ADDR_W-1:0] exec_addr_i,
    input  logic              st_chk_valid_i,
    input  logic [IDX_W-1:0]  st_chk_start_i,
    input  logic [ADDR_W-1:0] st_chk_addr_i,
    input  logic              commit_valid_i,
    input  logic [SEQ_W-1:0]  commit_seq_i,
    input  logic              squash_valid_i,
    input  logic [SEQ_W-1:0]  squash_seq_i,
    input  logic              viol_rd_i,
    output logic              viol_valid_o,
    output logic [IDX_W-1:0]  viol_idx_o,
    output logic [SEQ_W-1:0]  viol_seq_o,
    output logic [VCNT_W-1:0] viol_count_o,
    input  logic [SQC_W-1:0]  sq_used_i,
    output logic [FREE_W-1:0] free_count_o
);
    import lq_order_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0]             head;
        logic [IDX_W-1:0]             tail;
        logic [CNT_W-1:0]             cnt;
        logic [SLOTS-1:0]             occ;
        logic [SLOTS-1:0]             done;
        logic [SLOTS-1:0][SEQ_W-1:0]  seq;
        logic [SLOTS-1:0][ADDR_W-1:0] addr;
        logic                         vflag;
        logic [IDX_W-1:0]             vidx;
        logic [SEQ_W-1:0]             vseq;
        logic [VCNT_W-1:0]            vcnt;
    } lq_state_t;

    lq_state_t st_q, st_d;

    // Region hit vector for the store check.
    logic [SLOTS-1:0] hit_vec;
    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit_vec[g] = st_q.occ[g] && st_q.done[g] &&
            ((st_q.addr[g] >> REGION_SHIFT) == (st_chk_addr_i >> REGION_SHIFT));
    end

    lq_order_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_scan (
        .start_i (st_chk_start_i),
        .stop_i  (st_q.tail),
        .hit_i   (hit_vec),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    logic full_w;
    assign full_w = (st_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        logic [IDX_W-1:0] p;
        logic [IDX_W-1:0] q;
        logic             go;
        logic [CNT_W-1:0] n_ret;
        logic [CNT_W-1:0] n_sq;
        logic             do_alloc;

        st_d  = st_q;
        n_ret = '0;
        n_sq  = '0;

        // Execute update (before retire/squash so removal wins).
        if (exec_valid_i && (32'(exec_idx_i) < SLOTS) && st_q.occ[exec_idx_i]) begin
            st_d.addr[exec_idx_i] = exec_addr_i;
            st_d.done[exec_idx_i] = 1'b1;
        end

        // Commit from the head.
        p  = st_q.head;
        go = commit_valid_i;
        for (int k = 0; k < DEPTH; k++) begin
            if (go && (CNT_W'(k) < st_q.cnt) && (st_q.seq[p] <= commit_seq_i)) begin
                st_d.occ[p]  = 1'b0;
                st_d.done[p] = 1'b0;
                p            = IDX_W'(ring_next(32'(p), SLOTS));
                n_ret        = n_ret + CNT_W'(1);
            end else begin
                go = 1'b0;
            end
        end
        st_d.head = p;

        // Squash from the tail.
        p  = st_q.tail;
        go = squash_valid_i;
        for (int k = 0; k < DEPTH; k++) begin
            q = IDX_W'(ring_prev(32'(p), SLOTS));
            if (go && (CNT_W'(k) < st_q.cnt) && (st_q.seq[q] > squash_seq_i)) begin
                st_d.occ[q]  = 1'b0;
                st_d.done[q] = 1'b0;
                p            = q;
                n_sq         = n_sq + CNT_W'(1);
            end else begin
                go = 1'b0;
            end
        end
        st_d.tail = p;

        // Allocation at the tail.
        do_alloc = alloc_valid_i && !full_w && !squash_valid_i;
        if (do_alloc) begin
            st_d.occ[st_q.tail]  = 1'b1;
            st_d.done[st_q.tail] = 1'b0;
            st_d.seq[st_q.tail]  = alloc_seq_i;
            st_d.addr[st_q.tail] = '1;
            st_d.tail            = IDX_W'(ring_next(32'(st_q.tail), SLOTS));
        end
        st_d.cnt = st_q.cnt - n_ret - n_sq + CNT_W'(do_alloc);

        // Sticky violator with read-and-clear.
        if (st_q.vflag) begin
            if (viol_rd_i) st_d.vflag = 1'b0;
        end else if (st_chk_valid_i && scan_found) begin
            st_d.vflag = 1'b1;
            st_d.vidx  = scan_idx;
            st_d.vseq  = st_q.seq[scan_idx];
            st_d.vcnt  = st_q.vcnt + VCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_idx_o   = st_q.tail;
    assign lq_full_o    = full_w;
    assign lq_count_o   = st_q.cnt;
    assign viol_valid_o = st_q.vflag;
    assign viol_idx_o   = st_q.vidx;
    assign viol_seq_o   = st_q.vseq;
    assign viol_count_o = st_q.vcnt;

    always_comb begin
        int unsigned lq_free;
        int unsigned sq_free;
        lq_free      = SLOTS - 32'(st_q.cnt);
        sq_free      = SQ_SLOTS - 32'(sq_used_i);
        free_count_o = FREE_W'(((lq_free < sq_free) ? lq_free : sq_free) - 1);
    end

    // Assertions
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lq_count_o <= CNT_W'(DEPTH));

    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full_o && !commit_valid_i && !squash_valid_i) |=> $stable(lq_count_o));

    p_viol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid_o && !viol_rd_i) |=> (viol_valid_o && $stable(viol_idx_o) && $stable(viol_count_o)));

    p_viol_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_valid_o) |-> (viol_count_o == $past(viol_count_o) + VCNT_W'(1)));

    p_viol_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid_o && viol_rd_i) |=> !viol_valid_o);

    p_commit_shrink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_i && !alloc_valid_i) |=> (lq_count_o <= $past(lq_count_o)));

    p_squash_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid_i |=> (lq_count_o <= $past(lq_count_o)));

    p_no_dual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid_i && squash_valid_i));
endmodule

// File: tb/lq_order_unit_tb.sv
`timescale 1ns/100ps
module lq_order_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid_i = 0;
    logic [31:0] alloc_seq_i = 0;
    logic [3:0]  tail_idx_o;
    logic        lq_full_o;
    logic [3:0]  lq_count_o;
    logic        exec_valid_i = 0;
    logic [3:0]  exec_idx_i = 0;
    logic [31:0] exec_addr_i = 0;
    logic        st_chk_valid_i = 0;
    logic [3:0]  st_chk_start_i = 0;
    logic [31:0] st_chk_addr_i = 0;
    logic        commit_valid_i = 0;
    logic [31:0] commit_seq_i = 0;
    logic        squash_valid_i = 0;
    logic [31:0] squash_seq_i = 0;
    logic        viol_rd_i = 0;
    logic        viol_valid_o;
    logic [3:0]  viol_idx_o;
    logic [31:0] viol_seq_o;
    logic [15:0] viol_count_o;
    logic [3:0]  sq_used_i = 0;
    logic [3:0]  free_count_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lq_order_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_seq_i(alloc_seq_i),
        .tail_idx_o(tail_idx_o), .lq_full_o(lq_full_o), .lq_count_o(lq_count_o),
        .exec_valid_i(exec_valid_i), .exec_idx_i(exec_idx_i), .exec_addr_i(exec_addr_i),
        .st_chk_valid_i(st_chk_valid_i), .st_chk_start_i(st_chk_start_i),
        .st_chk_addr_i(st_chk_addr_i),
        .commit_valid_i(commit_valid_i), .commit_seq_i(commit_seq_i),
        .squash_valid_i(squash_valid_i), .squash_seq_i(squash_seq_i),
        .viol_rd_i(viol_rd_i), .viol_valid_o(viol_valid_o), .viol_idx_o(viol_idx_o),
        .viol_seq_o(viol_seq_o), .viol_count_o(viol_count_o),
        .sq_used_i(sq_used_i), .free_count_o(free_count_o)
    );

    // Free-count vectors with four loads held: {sq_used, expected free}.
    localparam int FREE_VEC [5][2] = '{'{0, 4}, '{5, 3}, '{8, 0}, '{2, 4}, '{4, 4}};

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid_i = 0; exec_valid_i = 0; st_chk_valid_i = 0;
        commit_valid_i = 0; squash_valid_i = 0; viol_rd_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic alloc(input int seq);
        alloc_valid_i = 1; alloc_seq_i = seq; tick();
    endtask

    task automatic exec_ld(input int idx, input int addr);
        exec_valid_i = 1; exec_idx_i = 4'(idx); exec_addr_i = addr; tick();
    endtask

    task automatic st_chk(input int start, input int addr);
        st_chk_valid_i = 1; st_chk_start_i = 4'(start); st_chk_addr_i = addr; tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset count", lq_count_o, 0);
        check("R1 reset full", lq_full_o, 0);
        check("R6 reset viol", viol_valid_o, 0);
        check("R5 reset vcount", viol_count_o, 0);
        check("R9 reset free", free_count_o, 8);

        // R2: three allocations at slots 0,1,2
        check("R2 first slot", tail_idx_o, 0);
        alloc(10); alloc(11); alloc(12);
        check("R2 count", lq_count_o, 3);
        check("R2 tail", tail_idx_o, 3);
        alloc(30);
        // R9 table walk, four loads held
        foreach (FREE_VEC[i]) begin
            sq_used_i = 4'(FREE_VEC[i][0]);
            #1;
            check("R9 free", free_count_o, FREE_VEC[i][1]);
        end
        sq_used_i = 0;
        // drop seq 30 (squash >12), keep 10..12
        squash_valid_i = 1; squash_seq_i = 12; tick();
        check("R8 squash one", lq_count_o, 3);
        check("R8 tail back", tail_idx_o, 3);

        // R3/R4: execute slots 0 and 2, slot 1 stays unexecuted
        exec_ld(0, 32'h1234);
        exec_ld(2, 32'h1299);
        st_chk(1, 32'h12FF);
        check("R3 skip unexecuted, R4 valid", viol_valid_o, 1);
        check("R4 idx", viol_idx_o, 2);
        check("R4 seq", viol_seq_o, 12);
        check("R5 count one", viol_count_o, 1);

        // R5: check while pending is not performed
        st_chk(0, 32'h1200);
        check("R5 pending idx", viol_idx_o, 2);
        check("R5 pending count", viol_count_o, 1);

        // R6: read and clear
        viol_rd_i = 1; #1;
        check("R6 read valid", viol_valid_o, 1);
        check("R6 read seq", viol_seq_o, 12);
        tick();
        check("R6 cleared", viol_valid_o, 0);

        // R4 first match from start 0 is slot 0
        st_chk(0, 32'h1200);
        check("R4 first match idx", viol_idx_o, 0);
        check("R5 count two", viol_count_o, 2);
        // R6: read together with a matching check
        viol_rd_i = 1; st_chk_valid_i = 1; st_chk_start_i = 2; st_chk_addr_i = 32'h1200;
        tick();
        check("R6 same-cycle valid", viol_valid_o, 0);
        check("R6 same-cycle count", viol_count_o, 2);

        // R4: region mismatch and empty range
        st_chk(0, 32'h5500);
        check("R4 mismatch", viol_valid_o, 0);
        st_chk(3, 32'h1200);
        check("R4 empty range", viol_valid_o, 0);

        // R7: commit bound 10 retires slot 0 only
        commit_valid_i = 1; commit_seq_i = 10; tick();
        check("R7 partial commit", lq_count_o, 2);
        // R10: commit with allocation
        commit_valid_i = 1; commit_seq_i = 11; alloc_valid_i = 1; alloc_seq_i = 13; tick();
        check("R10 commit+alloc count", lq_count_o, 2);
        check("R10 commit+alloc tail", tail_idx_o, 4);
        // R10: squash with allocation
        squash_valid_i = 1; squash_seq_i = 12; alloc_valid_i = 1; alloc_seq_i = 50; tick();
        check("R10 squash ignores alloc count", lq_count_o, 1);
        check("R10 squash ignores alloc tail", tail_idx_o, 3);

        // R2 wrap and R1 full
        for (int s = 20; s < 26; s++) alloc(s);
        check("R2 wrap tail", tail_idx_o, 0);
        alloc(26);
        check("R1 full", lq_full_o, 1);
        check("R1 full count", lq_count_o, 8);
        check("R9 free when full", free_count_o, 0);
        alloc(27);
        check("R1 alloc ignored count", lq_count_o, 8);
        check("R1 alloc ignored tail", tail_idx_o, 1);

        // R7: commit stops at first larger number
        commit_valid_i = 1; commit_seq_i = 21; tick();
        check("R7 stop at larger", lq_count_o, 5);
        commit_valid_i = 1; commit_seq_i = 32'hFFFF_FFF0; tick();
        check("R7 commit all", lq_count_o, 0);
        check("R7 not full", lq_full_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule